// File: doc/BRIEF.md
# Per-Pixel Colour Source Selector

This block turns a stream of pixels into a stream of 24-bit RGB colours. Every input pixel carries three things: an 8-bit palette index, a 32-bit direct-colour word and a 32-bit control word. The top byte of the control word picks the source. When it holds the direct key value and deep colour is enabled, the pixel's colour is unpacked from the direct word. In every other case the index is looked up in an external palette memory. That memory is read synchronously and has a read enable.

The pipeline has two stages. The palette address leaves the block in the same cycle as the input handshake. The direct-colour fields and the source decision travel through a matching register, so the two paths meet in step and pixels leave in the order they came in. Both stream edges use valid/ready. A single advance condition, "the output register is empty or is being taken", clocks every stage and also drives the palette read enable. When the output is back-pressured, the whole pipeline and the palette read data freeze together.

Two plain control inputs apply per pixel and are sampled at acceptance. One disables deep colour, which gives a pure indexed display. The other swaps the red and blue positions for a sink that expects BGR order.

Top module: `pss_top`

## Requirements
- R1: While reset is asserted, and after it is released, `out_valid` is 0 until a pixel has been accepted.
- R2: A pixel whose control word has bits 31:24 not equal to 8'h03 takes its colour from the palette, whatever the direct word and the remaining control bits hold.
- R3: A pixel with control bits 31:24 equal to 8'h03, accepted while `deep_en` is 1, outputs red = direct[23:16], green = direct[15:8] and blue = direct[7:0]. Direct bits 31:24 have no effect.
- R4: The palette is addressed with `pal_rd_idx` = `in_index`, and `pal_rd_en` is high in the accept cycle. The entry `pal_rdata` presents on the next clock (red in 23:16, green in 15:8, blue in 7:0) is the pixel's colour.
- R5: While `deep_en` is 0 at acceptance, every pixel uses the palette, including pixels whose control byte is 8'h03.
- R6: When `bgr_order` is 1 at acceptance, the pixel's output places blue in `out_rgb[23:16]` and red in `out_rgb[7:0]`, with green staying in 15:8. When it is 0, red is in 23:16 and blue is in 7:0. This applies to both sources.
- R7: Pixels leave in acceptance order. With `out_ready` held high, a pixel accepted on clock edge N is presented on `out_valid` from edge N+2, with no bubbles for back-to-back input.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_rgb` stay unchanged on the next cycle.
- R9: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| deep_en | input | 1 | 1 allows the direct-colour source |
| bgr_order | input | 1 | 1 swaps red and blue in the output |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_index | input | 8 | Palette index of the pixel |
| in_direct | input | 32 | Direct-colour word |
| in_ctrl | input | 32 | Per-pixel control word |
| pal_rd_en | output | 1 | Palette read enable |
| pal_rd_idx | output | 8 | Palette read address |
| pal_rdata | input | 24 | Palette entry, one clock after the enabled read |
| out_valid | output | 1 | Output colour valid |
| out_ready | input | 1 | Sink accepts the colour |
| out_rgb | output | 24 | Output colour |

## Verification
Control bytes are mixed on purpose. The stream contains the exact key 8'h03, keys differing in a single bit (8'h02, 8'h83, 8'h13), and zero. Direct and control filler bits are random, so a decoder that checks too few or too many bits is exposed. The same mixture is replayed with deep colour disabled and with BGR order, which separates the source decision from the channel placement. A final pass toggles input gaps and output back-pressure at random. This shows whether palette data and direct data stay aligned while the stages freeze. An exact two-cycle latency is checked only in the unthrottled passes.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic {
    SRC_PALETTE = 1'b0,
    SRC_DIRECT  = 1'b1
  } src_e;

  localparam int unsigned CHAN_W_DEF = 8;
  localparam int unsigned WORD_W_DEF = 32;
  localparam int unsigned IDX_W_DEF  = 8;
endpackage

// File: rtl/pss_decode.sv
module pss_decode
  import pss_pkg::*;
#(
  parameter int unsigned CTRL_W = 32,
  parameter int unsigned KEY_W  = 8,
  parameter logic [KEY_W-1:0] KEY = 8'h03,
  parameter int unsigned DIR_W  = 32,
  parameter int unsigned CHAN_W = 8,
  localparam int unsigned RGB_W = 3 * CHAN_W
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              deep_en,
  input  logic [DIR_W-1:0]  direct,
  output src_e              src,
  output logic [RGB_W-1:0]  direct_rgb
);
  logic [KEY_W-1:0] tag;

  assign tag = ctrl[CTRL_W-1 -: KEY_W];

  always_comb begin
    src = SRC_PALETTE;
    if (deep_en && (tag == KEY)) src = SRC_DIRECT;
  end

  // Low three channel bytes of the direct word, red highest; top byte dropped.
  assign direct_rgb = direct[RGB_W-1:0];
endmodule

// File: rtl/pss_order.sv
module pss_order #(
  parameter int unsigned CHAN_W = 8,
  localparam int unsigned RGB_W = 3 * CHAN_W
) (
  input  logic [RGB_W-1:0] rgb_in,
  input  logic             swap_rb,
  output logic [RGB_W-1:0] rgb_out
);
  logic [CHAN_W-1:0] ch [3];

  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : g_split
      assign ch[g] = rgb_in[g*CHAN_W +: CHAN_W];
    end
  endgenerate

  always_comb begin
    if (swap_rb) rgb_out = {ch[0], ch[1], ch[2]};
    else         rgb_out = {ch[2], ch[1], ch[0]};
  end
endmodule

// File: rtl/pss_stage.sv
module pss_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         in_vld,
  input  logic [W-1:0] in_data,
  output logic         out_vld,
  output logic [W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
    end else if (adv) begin
      out_vld <= in_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && in_vld) out_data <= in_data;
  end
endmodule

// File: rtl/pss_top.sv
module pss_top
  import pss_pkg::*;
#(
  parameter int unsigned IDX_W  = IDX_W_DEF,
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned CHAN_W = CHAN_W_DEF,
  parameter int unsigned KEY_W  = 8,
  parameter logic [KEY_W-1:0] KEY = 8'h03,
  localparam int unsigned RGB_W = 3 * CHAN_W,
  localparam int unsigned A_W   = RGB_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deep_en,
  input  logic              bgr_order,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_index,
  input  logic [WORD_W-1:0] in_direct,
  input  logic [WORD_W-1:0] in_ctrl,
  output logic              pal_rd_en,
  output logic [IDX_W-1:0]  pal_rd_idx,
  input  logic [RGB_W-1:0]  pal_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RGB_W-1:0]  out_rgb
);
  logic             adv;
  src_e             dec_src;
  logic [RGB_W-1:0] dec_rgb;
  logic [A_W-1:0]   a_in, a_q;
  logic             a_valid;
  src_e             a_src;
  logic             a_swap;
  logic [RGB_W-1:0] a_rgb, picked, ordered;

  assign adv        = !out_valid || out_ready;
  assign in_ready   = adv;
  assign pal_rd_en  = adv;
  assign pal_rd_idx = in_index;

  pss_decode #(
    .CTRL_W(WORD_W), .KEY_W(KEY_W), .KEY(KEY), .DIR_W(WORD_W), .CHAN_W(CHAN_W)
  ) u_decode (
    .ctrl(in_ctrl), .deep_en(deep_en), .direct(in_direct),
    .src(dec_src), .direct_rgb(dec_rgb)
  );

  assign a_in = {dec_src == SRC_DIRECT, bgr_order, dec_rgb};

  // Stage A: aligned with the palette memory read.
  pss_stage #(.W(A_W)) u_stage_a (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_vld(in_valid), .in_data(a_in),
    .out_vld(a_valid), .out_data(a_q)
  );

  assign a_src  = a_q[A_W-1] ? SRC_DIRECT : SRC_PALETTE;
  assign a_swap = a_q[A_W-2];
  assign a_rgb  = a_q[RGB_W-1:0];
  assign picked = (a_src == SRC_DIRECT) ? a_rgb : pal_rdata;

  pss_order #(.CHAN_W(CHAN_W)) u_order (
    .rgb_in(picked), .swap_rb(a_swap), .rgb_out(ordered)
  );

  // Stage B: output register.
  pss_stage #(.W(RGB_W)) u_stage_b (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_vld(a_valid), .in_data(ordered),
    .out_vld(out_valid), .out_data(out_rgb)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb))); // R8

  AST_ACCEPT_FILLS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> a_valid); // R7

  AST_A_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && in_ready) |=> out_valid); // R7

  AST_NONKEY_PALETTE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_ctrl[WORD_W-1 -: KEY_W] != KEY))
      |=> (a_src == SRC_PALETTE)); // R2

  AST_SHALLOW_PALETTE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !deep_en) |=> (a_src == SRC_PALETTE)); // R5
endmodule

// File: tb/test_pss_top.sv
module test_pss_top;
  logic        clk = 1'b0;
  logic        rst_n, deep_en, bgr_order, in_valid, in_ready;
  logic [7:0]  in_index;
  logic [31:0] in_direct, in_ctrl;
  logic        pal_rd_en;
  logic [7:0]  pal_rd_idx;
  logic [23:0] pal_q;
  logic        out_valid, out_ready;
  logic [23:0] out_rgb;

  always #10 clk = ~clk;

  pss_top i_pss_top (
    .clk(clk), .rst_n(rst_n), .deep_en(deep_en), .bgr_order(bgr_order),
    .in_valid(in_valid), .in_ready(in_ready), .in_index(in_index),
    .in_direct(in_direct), .in_ctrl(in_ctrl), .pal_rd_en(pal_rd_en),
    .pal_rd_idx(pal_rd_idx), .pal_rdata(pal_q), .out_valid(out_valid),
    .out_ready(out_ready), .out_rgb(out_rgb)
  );

  function automatic logic [23:0] pal_entry(input logic [7:0] i);
    return {i ^ 8'h5A, i + 8'd17, ~i};
  endfunction

  always @(posedge clk) if (pal_rd_en) pal_q <= pal_entry(pal_rd_idx);

  int checks = 0, errors = 0, cyc = 0, k = 0;
  bit mon_on = 0, chk_lat = 0, acc_flag = 0, prev_hold = 0, done = 0;
  logic [23:0] prev_rgb;
  logic [23:0] q_rgb[$];
  int          q_cyc[$];
  string       q_tag[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      acc_flag = in_valid && in_ready;
      if (acc_flag) begin
        logic [23:0] e;
        string t;
        bit key;
        key = (in_ctrl[31:24] == 8'h03);
        if (key && deep_en) begin e = in_direct[23:0]; t = "R3"; end
        else begin
          e = pal_entry(in_index);
          t = key ? "R5" : ((in_ctrl[31:24] == 8'h00) ? "R4" : "R2");
        end
        if (bgr_order) begin e = {e[7:0], e[15:8], e[23:16]}; t = "R6"; end
        q_rgb.push_back(e); q_cyc.push_back(cyc); q_tag.push_back(t);
      end
      check(in_ready == (!out_valid || out_ready), "R9 in_ready", {31'd0, in_ready}, {31'd0, !out_valid || out_ready});
      if (prev_hold) begin
        check(out_valid === 1'b1, "R8 valid held", {31'd0, out_valid}, 32'd1);
        check(out_rgb === prev_rgb, "R8 data held", {8'd0, out_rgb}, {8'd0, prev_rgb});
      end
      if (out_valid && out_ready) begin
        if (q_rgb.size() == 0) check(1'b0, "R7 unexpected output", {8'd0, out_rgb}, 32'd0);
        else begin
          logic [23:0] e;
          int c;
          string t;
          e = q_rgb.pop_front(); c = q_cyc.pop_front(); t = q_tag.pop_front();
          check(out_rgb === e, t, {8'd0, out_rgb}, {8'd0, e});
          if (chk_lat) check(cyc - c == 2, "R7 latency", cyc - c, 32'd2);
        end
      end
      prev_hold = out_valid && !out_ready;
      prev_rgb  = out_rgb;
    end else acc_flag = 0;
  end

  task automatic new_pixel();
    logic [7:0] top;
    case (k % 7)
      0, 1:    top = 8'h03;
      2:       top = 8'h00;
      3:       top = 8'h02;
      4:       top = 8'h83;
      5:       top = 8'h13;
      default: top = 8'h03;
    endcase
    in_index  = 8'($urandom);
    in_direct = $urandom;
    in_ctrl   = {top, 24'($urandom)};
    k++;
  endtask

  task automatic run(input int n, input bit rv, input bit rr);
    int sent = 0;
    while (sent < n) begin
      @(posedge clk); #2;
      if (in_valid && acc_flag) sent++;
      out_ready = rr ? (($urandom % 4) != 0) : 1'b1;
      if (!in_valid || acc_flag) begin
        if (sent < n && (!rv || ($urandom % 3) != 0)) begin in_valid = 1; new_pixel(); end
        else in_valid = 0;
      end
    end
    in_valid = 0; out_ready = 1;
    repeat (6) @(posedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; deep_en = 1; bgr_order = 0; in_valid = 0; out_ready = 1;
    in_index = 0; in_direct = 0; in_ctrl = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R1 valid in reset", {31'd0, out_valid}, 32'd0);
    @(posedge clk); #2 rst_n = 1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 valid after reset", {31'd0, out_valid}, 32'd0);
    check(in_ready === 1'b1, "R9 ready after reset", {31'd0, in_ready}, 32'd1);
    mon_on = 1; chk_lat = 1;
    run(60, 0, 0);                     // R2 R3 R4 R7 deep, RGB order
    deep_en = 0; run(40, 0, 0);        // R5 shallow
    deep_en = 1; bgr_order = 1; run(40, 0, 0); // R6
    chk_lat = 0; bgr_order = 0; run(150, 1, 1); // R8 back-pressure
    bgr_order = 1; run(80, 1, 1);
    check(q_rgb.size() == 0, "R7 all pixels out", q_rgb.size(), 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule